// File: doc/BRIEF.md
# Multi-byte in-frame response transmit sequencer

This block sequences a multi-byte in-frame response (IFR) without CRC on a J1850-style serial bus. The host arms a request before the frame's end-of-data symbol arrives. It feeds response bytes through a one-byte data holding register, paced by a holding-register-empty flag, and it marks the final byte with an end-of-data request.

When a valid end-of-data symbol with good CRC is received while armed, the block asks its transmit stage for a normalization symbol. It then shifts each byte out most significant bit first, one data-bit symbol at a time, and closes with an end-of-data symbol. No CRC byte is added.

The transmit stage is modelled as a handshake. The block raises a one-cycle symbol request with a kind code, and the stage answers with either done or lost, where lost means arbitration was lost on that symbol. Arbitration loss, bus errors, host underrun and an over-long response each stop the sequence, and none of them is retried.

Top module: `ifr_mtx_seq`

## Requirements
- R1: After reset, armed, lost_flg, len_flg and tx_sym_req are 0 and tdre is 1.
- R2: A pulse on arm_req sets armed only if no end-of-data symbol has been received since the last rx_sof. Otherwise armed stays 0 and no symbol is requested, even after a later rx_eod with good CRC.
- R3: While armed, an rx_eod with rx_crc_ok=1 starts the sequence. The block requests one normalization symbol (kind 0) and then the holding-register byte as 8 data-bit symbols (kind 1), most significant bit first, with the bit on tx_bit. An rx_eod with rx_crc_ok=0 clears armed and requests nothing.
- R4: tdre is 1 while the holding register is empty. It falls after a dr_wr and rises when the byte moves into the shift register.
- R5: Once eod_req has been pulsed, further dr_wr pulses are ignored. After the last held byte is shifted out, one end-of-data symbol (kind 2) is requested with no CRC byte before it, and then armed clears.
- R6: If tx_lost answers the normalization symbol or any of data bits 0 to DW-3 of a byte (bit 0 being the first bit sent), lost_flg is set, armed clears and no further symbol is requested.
- R7: If tx_lost answers either of the last two data bits of a byte, lost_flg is set and armed clears. Exactly two more data-bit symbols with tx_bit=1 are then requested, and nothing after them.
- R8: An rx_bus_err pulse clears armed and stops the sequence, so no further symbol is requested.
- R9: If a byte finishes while the holding register is empty and no eod_req is pending, armed clears and neither another data bit nor an end-of-data symbol is requested.
- R10: At most MAX_BYTES bytes are sent per response. If a further byte is waiting after MAX_BYTES bytes have gone out, len_flg is set, armed clears and no end-of-data symbol is requested. A response of exactly MAX_BYTES bytes ends normally.
- R11: tx_sym_req lasts one cycle, and no new request is made until tx_done or tx_lost has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_req | input | 1 | Host pulse: request a multi-byte IFR |
| eod_req | input | 1 | Host pulse: the held byte is the last |
| dr_wr | input | 1 | Host pulse: write dr_data into holding register |
| dr_data | input | DW | Byte to transmit |
| rx_sof | input | 1 | Start-of-frame symbol received |
| rx_eod | input | 1 | End-of-data symbol received |
| rx_crc_ok | input | 1 | CRC status qualifying rx_eod |
| rx_bus_err | input | 1 | Bus error detected |
| tx_done | input | 1 | Transmit stage finished the requested symbol |
| tx_lost | input | 1 | Arbitration lost on the requested symbol |
| tx_sym_req | output | 1 | One-cycle symbol request |
| tx_sym_kind | output | 2 | 0 normalization, 1 data bit, 2 end-of-data |
| tx_bit | output | 1 | Data bit value for kind 1 |
| armed | output | 1 | IFR request bit |
| tdre | output | 1 | Holding register empty |
| lost_flg | output | 1 | Arbitration was lost (cleared on accepted arm) |
| len_flg | output | 1 | Length limit hit (cleared on accepted arm) |

## Verification
The bench builds the block with DW=8 and MAX_BYTES=3. A three-byte limit lets one short response reach the ceiling exactly and another exceed it by one byte. An emulated transmit stage answers every request after a fixed delay and can be told to report lost arbitration on a chosen symbol index. This makes it possible to aim at the last-two-bit boundary that separates R6 from R7.

// File: rtl/ifr_mtx_seq.sv
module ifr_mtx_seq #(
  parameter int DW = 8,
  parameter int MAX_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_req,
  input  logic          eod_req,
  input  logic          dr_wr,
  input  logic [DW-1:0] dr_data,
  input  logic          rx_sof,
  input  logic          rx_eod,
  input  logic          rx_crc_ok,
  input  logic          rx_bus_err,
  input  logic          tx_done,
  input  logic          tx_lost,
  output logic          tx_sym_req,
  output logic [1:0]    tx_sym_kind,
  output logic          tx_bit,
  output logic          armed,
  output logic          tdre,
  output logic          lost_flg,
  output logic          len_flg
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam logic [1:0] K_NORM = 2'd0;
  localparam logic [1:0] K_DATA = 2'd1;
  localparam logic [1:0] K_EOD  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_LOAD, S_BIT, S_PAD, S_EOD} st_t;

  st_t            st;
  logic           wait_q, eod_seen, dr_full, eod_pend, padn;
  logic [DW-1:0]  dr, sh;
  logic [BW-1:0]  bitn;
  logic [CW-1:0]  nbytes;

  wire in_tx = (st == S_NORM) || (st == S_BIT) || (st == S_PAD) || (st == S_EOD);
  wire resp  = wait_q && (tx_done || tx_lost);

  assign tx_sym_req  = in_tx && !wait_q;
  assign tx_sym_kind = (st == S_NORM) ? K_NORM : (st == S_EOD) ? K_EOD : K_DATA;
  assign tx_bit      = (st == S_PAD) ? 1'b1 : sh[DW-1];
  assign tdre        = !dr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wait_q   <= 1'b0;
      eod_seen <= 1'b0;
      dr_full  <= 1'b0;
      eod_pend <= 1'b0;
      padn     <= 1'b0;
      dr       <= '0;
      sh       <= '0;
      bitn     <= '0;
      nbytes   <= '0;
      armed    <= 1'b0;
      lost_flg <= 1'b0;
      len_flg  <= 1'b0;
    end else begin
      if (tx_sym_req) wait_q <= 1'b1;
      else if (resp)  wait_q <= 1'b0;

      if (rx_sof)      eod_seen <= 1'b0;
      else if (rx_eod) eod_seen <= 1'b1;

      if (eod_req && armed)               eod_pend <= 1'b1;
      else if (st == S_IDLE && !armed)    eod_pend <= 1'b0;

      case (st)
        S_IDLE: begin
          if (arm_req && !eod_seen && !armed) begin
            armed    <= 1'b1;
            lost_flg <= 1'b0;
            len_flg  <= 1'b0;
          end
          if (armed && rx_eod) begin
            if (rx_crc_ok) begin
              st     <= S_NORM;
              nbytes <= '0;
            end else begin
              armed  <= 1'b0;
            end
          end
        end
        S_NORM: if (resp) begin
          if (tx_lost) begin
            lost_flg <= 1'b1;
            armed    <= 1'b0;
            st       <= S_IDLE;
          end else begin
            st <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (dr_full) begin
            if (nbytes == CW'(MAX_BYTES)) begin
              len_flg <= 1'b1;
              armed   <= 1'b0;
              st      <= S_IDLE;
            end else begin
              sh      <= dr;
              dr_full <= 1'b0;
              nbytes  <= nbytes + 1'b1;
              bitn    <= '0;
              st      <= S_BIT;
            end
          end else if (eod_pend) begin
            st <= S_EOD;
          end else begin
            armed <= 1'b0;
            st    <= S_IDLE;
          end
        end
        S_BIT: if (resp) begin
          if (tx_lost) begin
            lost_flg <= 1'b1;
            armed    <= 1'b0;
            padn     <= 1'b0;
            st       <= (int'(bitn) >= DW - 2) ? S_PAD : S_IDLE;
          end else if (bitn == BW'(DW - 1)) begin
            st <= S_LOAD;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[DW-2:0], 1'b0};
          end
        end
        S_PAD: if (resp) begin
          if (padn) st <= S_IDLE;
          padn <= 1'b1;
        end
        S_EOD: if (resp) begin
          if (tx_lost) lost_flg <= 1'b1;
          armed <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (dr_wr && !eod_pend) begin
        dr      <= dr_data;
        dr_full <= 1'b1;
      end

      if (rx_bus_err) begin
        armed  <= 1'b0;
        st     <= S_IDLE;
        wait_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ifr_mtx_seq_chk.sv
module ifr_mtx_seq_chk #(
  parameter int DW = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_sof,
  input logic       rx_eod,
  input logic       rx_bus_err,
  input logic       tx_done,
  input logic       tx_lost,
  input logic       tx_sym_req,
  input logic [1:0] tx_sym_kind,
  input logic       tx_bit,
  input logic       armed,
  input logic       lost_flg
);
  localparam int CW = $clog2(DW) + 1;
  logic outst, seen_q;
  logic [CW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst  <= 1'b0;
      seen_q <= 1'b0;
      dcnt   <= '0;
    end else begin
      if (tx_sym_req) outst <= 1'b1;
      else if (tx_done || tx_lost) outst <= 1'b0;
      if (rx_sof) seen_q <= 1'b0;
      else if (rx_eod) seen_q <= 1'b1;
      if (tx_sym_req && tx_sym_kind == 2'd0) dcnt <= '0;
      else if (tx_sym_req && tx_sym_kind == 2'd1 && armed)
        dcnt <= (dcnt == CW'(DW - 1)) ? '0 : dcnt + 1'b1;
    end
  end

  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym_req |=> !tx_sym_req);
  a_r11_wait_resp: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !tx_sym_req);
  a_r2_late_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !armed) |=> !armed);
  a_r5_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sym_req && tx_sym_kind == 2'd2) |-> (dcnt == '0));
  a_r6_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && tx_lost) |=> (!armed && lost_flg));
  a_r7_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sym_req && !armed) |-> (tx_sym_kind == 2'd1 && tx_bit));
  a_r8_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bus_err |=> !armed);
endmodule

bind ifr_mtx_seq ifr_mtx_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_eod(rx_eod),
  .rx_bus_err(rx_bus_err), .tx_done(tx_done), .tx_lost(tx_lost),
  .tx_sym_req(tx_sym_req), .tx_sym_kind(tx_sym_kind), .tx_bit(tx_bit),
  .armed(armed), .lost_flg(lost_flg)
);

// File: tb/ifr_mtx_seq_test.sv
`timescale 1ns/1ps
module ifr_mtx_seq_test;
  localparam int DW = 8;
  localparam int MAXB = 3;

  logic clk = 0, rst_n = 0;
  logic arm_req = 0, eod_req = 0, dr_wr = 0, rx_sof = 0, rx_eod = 0;
  logic rx_crc_ok = 0, rx_bus_err = 0, tx_done = 0, tx_lost = 0;
  logic [DW-1:0] dr_data = 0;
  logic tx_sym_req, tx_bit, armed, tdre, lost_flg, len_flg;
  logic [1:0] tx_sym_kind;

  always #2.5 clk = ~clk;

  ifr_mtx_seq #(.DW(DW), .MAX_BYTES(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .eod_req(eod_req),
    .dr_wr(dr_wr), .dr_data(dr_data), .rx_sof(rx_sof), .rx_eod(rx_eod),
    .rx_crc_ok(rx_crc_ok), .rx_bus_err(rx_bus_err), .tx_done(tx_done),
    .tx_lost(tx_lost), .tx_sym_req(tx_sym_req), .tx_sym_kind(tx_sym_kind),
    .tx_bit(tx_bit), .armed(armed), .tdre(tdre), .lost_flg(lost_flg),
    .len_flg(len_flg));

  int total = 0, bad = 0, n = 0, lose_at = -1, dly = 0;
  bit lose_now = 0, finished = 0;
  logic [1:0] kinds [64];
  logic       bits  [64];

  always @(negedge clk) begin
    tx_done = 0;
    tx_lost = 0;
    if (dly > 0) begin
      dly = dly - 1;
      if (dly == 0) begin
        if (lose_now) tx_lost = 1; else tx_done = 1;
      end
    end
    if (tx_sym_req && n < 64) begin
      kinds[n] = tx_sym_kind;
      bits[n]  = tx_bit;
      lose_now = (n == lose_at);
      n = n + 1;
      dly = 2;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_byte(string tag, int start, logic [DW-1:0] exp);
    logic [DW-1:0] got = '0;
    int kd = 1;
    for (int i = 0; i < DW; i++) begin
      got[DW-1-i] = bits[start+i];
      if (kinds[start+i] != 2'd1) kd = 0;
    end
    chk({tag, " data kind"}, kd, 1);
    chk({tag, " byte msb first"}, int'(got), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 0; arm_req = 0; eod_req = 0; dr_wr = 0; rx_sof = 0; rx_eod = 0;
    rx_crc_ok = 0; rx_bus_err = 0;
    repeat (3) @(negedge clk);
    n = 0; lose_at = -1; dly = 0; lose_now = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic p_arm(); arm_req = 1; @(negedge clk); arm_req = 0; endtask
  task automatic p_eodq(); eod_req = 1; @(negedge clk); eod_req = 0; endtask
  task automatic p_sof(); rx_sof = 1; @(negedge clk); rx_sof = 0; endtask
  task automatic p_wr(logic [DW-1:0] b);
    dr_data = b; dr_wr = 1; @(negedge clk); dr_wr = 0;
  endtask
  task automatic p_rxeod(logic ok);
    rx_eod = 1; rx_crc_ok = ok; @(negedge clk); rx_eod = 0; rx_crc_ok = 0;
  endtask
  task automatic wait_tdre();
    for (int i = 0; i < 500 && !tdre; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 armed", armed, 0);
    chk("R1 tdre", tdre, 1);
    chk("R1 lost_flg", lost_flg, 0);
    chk("R1 len_flg", len_flg, 0);
    chk("R1 tx_sym_req", tx_sym_req, 0);
  endtask

  task automatic t_two_bytes();
    do_reset();
    p_arm();
    chk("R2 armed after early arm", armed, 1);
    chk("R4 tdre before write", tdre, 1);
    p_wr(8'hA5);
    chk("R4 tdre after write", tdre, 0);
    p_rxeod(1);
    wait_tdre();
    chk("R4 tdre after move to shifter", tdre, 1);
    p_wr(8'h3C);
    p_eodq();
    p_wr(8'hFF);
    repeat (300) @(negedge clk);
    chk("R3 first symbol normalization", kinds[0], 0);
    chk_byte("R3 byte0", 1, 8'hA5);
    chk_byte("R5 byte1", 9, 8'h3C);
    chk("R5 eod symbol", kinds[17], 2);
    chk("R5 symbol count (no crc, write ignored)", n, 18);
    chk("R5 armed cleared after eod", armed, 0);
    chk("R11 lost_flg clean", lost_flg, 0);
  endtask

  task automatic t_late_arm();
    do_reset();
    p_rxeod(1);
    p_arm();
    chk("R2 late arm ignored", armed, 0);
    p_wr(8'h11);
    p_rxeod(1);
    repeat (40) @(negedge clk);
    chk("R2 no symbols after late arm", n, 0);
    p_sof();
    p_arm();
    chk("R2 arm after new frame", armed, 1);
  endtask

  task automatic t_bad_crc();
    do_reset();
    p_arm();
    p_wr(8'h5A);
    p_rxeod(0);
    repeat (40) @(negedge clk);
    chk("R3 bad crc clears armed", armed, 0);
    chk("R3 bad crc sends nothing", n, 0);
  endtask

  task automatic t_lost(int idx, int exp_n, string tag);
    do_reset();
    lose_at = idx;
    p_arm();
    p_wr(8'h00);
    p_rxeod(1);
    wait_tdre();
    p_wr(8'h77);
    repeat (200) @(negedge clk);
    chk({tag, " symbol count"}, n, exp_n);
    chk({tag, " lost_flg"}, lost_flg, 1);
    chk({tag, " armed"}, armed, 0);
  endtask

  task automatic t_lost_late();
    t_lost(7, 10, "R7");
    chk("R7 pad0 kind", kinds[8], 1);
    chk("R7 pad0 bit", bits[8], 1);
    chk("R7 pad1 kind", kinds[9], 1);
    chk("R7 pad1 bit", bits[9], 1);
  endtask

  task automatic t_bus_err();
    int m;
    do_reset();
    p_arm();
    p_wr(8'hC3);
    p_rxeod(1);
    for (int i = 0; i < 200 && n < 5; i++) @(negedge clk);
    rx_bus_err = 1; @(negedge clk); rx_bus_err = 0;
    @(negedge clk);
    m = n;
    repeat (100) @(negedge clk);
    chk("R8 armed cleared", armed, 0);
    chk("R8 no symbols after error", n, m);
  endtask

  task automatic t_underrun();
    do_reset();
    p_arm();
    p_wr(8'h81);
    p_rxeod(1);
    repeat (200) @(negedge clk);
    chk("R9 symbol count", n, 9);
    chk("R9 no eod after underrun", kinds[8], 1);
    chk("R9 armed cleared", armed, 0);
  endtask

  task automatic t_len(int nb, bit with_eod, string tag);
    do_reset();
    p_arm();
    p_wr(8'h01);
    p_rxeod(1);
    for (int i = 1; i < nb; i++) begin
      wait_tdre();
      p_wr(8'(i + 1));
    end
    if (with_eod) p_eodq();
    repeat (400) @(negedge clk);
    if (with_eod) begin
      chk({tag, " count at limit"}, n, 1 + DW*MAXB + 1);
      chk({tag, " eod at limit"}, kinds[1 + DW*MAXB], 2);
      chk({tag, " len_flg at limit"}, len_flg, 0);
      chk_byte({tag, " last byte"}, 1 + DW*(MAXB-1), 8'(MAXB));
    end else begin
      chk({tag, " count over limit"}, n, 1 + DW*MAXB);
      chk({tag, " len_flg over limit"}, len_flg, 1);
      chk({tag, " armed over limit"}, armed, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_two_bytes();
    t_late_arm();
    t_bad_crc();
    t_lost(3, 4, "R6");
    t_lost(0, 1, "R6 norm");
    t_lost_late();
    t_bus_err();
    t_underrun();
    t_len(MAXB, 1, "R10");
    t_len(MAXB + 1, 0, "R10");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule